// File: doc/BRIEF.md
# Ranked Inbound Message Scheduler with Per-Address Parking

This block sits in front of a cache controller's transition logic. It picks one message per cycle from three inbound queues. Queue 0 carries responses from the lower level. Queue 1 carries requests from the lower level. Queue 2 carries requests from the upper cache. The pick uses a fixed rank. The chosen message leaves on a single output together with its source queue and the channel it arrived on.

A controller outside the block decides which addresses are busy and answers a per-queue blocked query. When the head of a queue targets a busy address, the block accepts that message and parks it in the queue's own waiting list. A later message in the same queue for an address that already has a parked, unreleased entry is parked as well. A wake-up strobe that carries an address releases every parked entry for that address in all three queues. Released entries are then presented again in arrival order, ahead of any new traffic in their queue.

An upper-cache request flagged as needing a victim is presented under the victim's address and marked as a replacement. A small tag lookup maps the kind of an outbound message to its virtual channel and issue delay.

Top module: `msg_rank_sched`

## Requirements
- R1: When several queues offer a message in the same cycle, queue 0 (lower-level response) wins over queue 1 (lower-level request), and queue 1 wins over queue 2 (upper-cache request). Exactly one message is output whenever any queue has a presentable message.
- R2: A message that is not blocked and has no parked entry for its address in its queue is output combinationally in the cycle it is offered. Its `sel_src` equals the queue index, and only the winning queue sees `in_ready` high.
- R3: A message whose queue has `qry_blocked` high is accepted (`in_ready` high) and parked, and it is not output.
- R4: A message whose address matches an unreleased parked entry of its own queue is parked even when it is not blocked.
- R5: A wake-up releases every parked entry with that address. The released entries of a queue are output in their arrival order. While a queue has a released entry pending, its `in_ready` is low.
- R6: Parked entries whose address differs from the wake-up address stay parked and are not output.
- R7: While a queue's waiting list (depth `PARK_DEPTH`) is full, its `in_ready` is low.
- R8: For queue 2 with `victim_en` high, the effective address is `victim_addr`. This address is used on `qry_addr[2]` and `sel_addr`, and `sel_repl` is 1.
- R9: `tx_kind` 0 (request) gives channel 0 and delay 2. Kind 1 (response) gives channel 1 and delay 2. Kind 2 (unblock) gives channel 2 and delay 1. Kind 3 gives channel 0 and delay 0.
- R10: `sel_vc` is 1 for queue 0, 2 for queue 1, and 0 for queue 2.
- R11: After reset no entry is parked, and with no input valid `sel_valid` is low.
- R12: A message parked in the same cycle as a wake-up for its address is released at once and is output in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 3 | Per-queue message valid |
| in_ready | output | 3 | Per-queue accept |
| in_addr | input | 3xAW | Per-queue message address |
| in_data | input | 3xDW | Per-queue message payload |
| victim_en | input | 1 | Queue 2 message needs a victim replacement |
| victim_addr | input | AW | Victim address for queue 2 |
| qry_addr | output | 3xAW | Effective address queried per queue |
| qry_blocked | input | 3 | Query answer: address busy |
| wake_valid | input | 1 | Wake-up strobe |
| wake_addr | input | AW | Address being woken |
| sel_valid | output | 1 | A message is selected |
| sel_src | output | 2 | Source queue of the selection |
| sel_vc | output | 2 | Inbound channel of the selection |
| sel_addr | output | AW | Selected effective address |
| sel_data | output | DW | Selected payload |
| sel_repl | output | 1 | Selection is a victim replacement |
| tx_kind | input | 2 | Outbound message kind |
| tx_vc | output | 2 | Outbound virtual channel |
| tx_lat | output | LATW | Outbound issue delay in cycles |

## Verification
The bench parks two same-address messages, one blocked and one unblocked. A design that checked only the blocked query would let the second message overtake the first. It then wakes an unrelated address, which must release nothing; a design with a loose address compare would drain the list early. Next it fills a waiting list and checks that ready drops, since an overflowing design would silently overwrite its oldest entry. It drains the list after a wake and checks strict arrival order, which a design that reversed its slot scan would get wrong. A wake that lands in the same cycle as a park must not strand the new entry, and a victim request must show the victim address rather than the requested one.

// File: rtl/msg_sched_pkg.sv
package msg_sched_pkg;
   localparam int NUM_Q = 3;

   typedef enum logic [1:0] {
      SRC_RSP  = 2'd0,
      SRC_LREQ = 2'd1,
      SRC_UREQ = 2'd2
   } src_e;

   typedef enum logic [1:0] {
      TXK_REQ  = 2'd0,
      TXK_RSP  = 2'd1,
      TXK_UNB  = 2'd2,
      TXK_NONE = 2'd3
   } txk_e;
endpackage

// File: rtl/rank_pick.sv
module rank_pick #(
   parameter int N  = 3,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic [N-1:0]  gnt,
   output logic [IW-1:0] gnt_idx,
   output logic          any
);
   logic [N:0] taken;

   assign taken[0] = 1'b0;

   genvar g;
   generate
      for (g = 0; g < N; g++) begin : g_rank
         assign gnt[g]     = req[g] & ~taken[g];
         assign taken[g+1] = taken[g] | req[g];
      end
   endgenerate

   assign any = taken[N];

   always_comb begin
      gnt_idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) gnt_idx = IW'(i);
      end
   end
endmodule

// File: rtl/park_lane.sv
module park_lane #(
   parameter int AW    = 16,
   parameter int DW    = 16,
   parameter int DEPTH = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [AW-1:0] in_addr,
   input  logic [DW-1:0] in_data,
   input  logic          in_flag,
   input  logic          blocked,
   input  logic          grant,
   input  logic          wake_valid,
   input  logic [AW-1:0] wake_addr,
   output logic          in_ready,
   output logic          cand_valid,
   output logic [AW-1:0] cand_addr,
   output logic [DW-1:0] cand_data,
   output logic          cand_flag
);
   localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("park_lane: DEPTH must be at least 1");
      end
   endgenerate

   logic [DEPTH-1:0] vld_q, rel_q;
   logic [AW-1:0]    addr_q [DEPTH];
   logic [DW-1:0]    data_q [DEPTH];
   logic [DEPTH-1:0] flag_q;

   logic [DEPTH-1:0] n_vld, n_rel, n_flag, wrel;
   logic [AW-1:0]    n_addr [DEPTH];
   logic [DW-1:0]    n_data [DEPTH];

   logic          rel_any, match, full, must_park, push, pop;
   logic [IW-1:0] rel_idx, free_idx;

   // Scan the waiting list: oldest released slot, first free slot, address match.
   always_comb begin
      rel_any  = 1'b0;
      rel_idx  = '0;
      free_idx = '0;
      match    = 1'b0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (vld_q[i] && rel_q[i]) begin
            rel_any = 1'b1;
            rel_idx = IW'(i);
         end
         if (!vld_q[i]) free_idx = IW'(i);
      end
      for (int i = 0; i < DEPTH; i++) begin
         if (vld_q[i] && !rel_q[i] && (addr_q[i] == in_addr)) match = 1'b1;
      end
   end

   assign full      = vld_q[DEPTH-1];
   assign must_park = blocked | match;
   assign in_ready  = !full && !rel_any && (must_park || grant);
   assign push      = in_valid && in_ready && must_park;
   assign pop       = grant && rel_any;

   assign cand_valid = rel_any || (in_valid && !full && !must_park);
   assign cand_addr  = rel_any ? addr_q[rel_idx] : in_addr;
   assign cand_data  = rel_any ? data_q[rel_idx] : in_data;
   assign cand_flag  = rel_any ? flag_q[rel_idx] : in_flag;

   always_comb begin
      for (int i = 0; i < DEPTH; i++) begin
         wrel[i] = rel_q[i] | (wake_valid && (addr_q[i] == wake_addr));
      end
      n_vld  = vld_q;
      n_rel  = wrel;
      n_flag = flag_q;
      n_addr = addr_q;
      n_data = data_q;
      if (pop) begin
         for (int i = 0; i < DEPTH - 1; i++) begin
            if (i >= int'(rel_idx)) begin
               n_vld[i]  = vld_q[i+1];
               n_rel[i]  = wrel[i+1];
               n_flag[i] = flag_q[i+1];
               n_addr[i] = addr_q[i+1];
               n_data[i] = data_q[i+1];
            end
         end
         n_vld[DEPTH-1] = 1'b0;
         n_rel[DEPTH-1] = 1'b0;
      end
      if (push) begin
         n_vld[free_idx]  = 1'b1;
         n_rel[free_idx]  = wake_valid && (wake_addr == in_addr);
         n_flag[free_idx] = in_flag;
         n_addr[free_idx] = in_addr;
         n_data[free_idx] = in_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q  <= '0;
         rel_q  <= '0;
         flag_q <= '0;
      end else begin
         vld_q  <= n_vld;
         rel_q  <= n_rel;
         flag_q <= n_flag;
      end
   end

   always_ff @(posedge clk) begin
      addr_q <= n_addr;
      data_q <= n_data;
   end

   // Checker state: unreleased slots that still hold last cycle's wake address.
   logic [AW-1:0]    wake_addr_d;
   logic [DEPTH-1:0] stale;
   always_ff @(posedge clk) wake_addr_d <= wake_addr;
   always_comb begin
      for (int i = 0; i < DEPTH; i++) begin
         stale[i] = vld_q[i] && !rel_q[i] && (addr_q[i] == wake_addr_d);
      end
   end

   // R7
   full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_q[DEPTH-1] && !pop) |=> vld_q[DEPTH-1]);

   // R4
   park_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && match) |=>
      ($countones(vld_q) == $past($countones(vld_q)) + 1));

   // R5
   wake_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wake_valid |=> (stale == '0));

   // R5
   pop_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant && rel_any) |=>
      ($countones(vld_q) + 1 == $past($countones(vld_q))));
endmodule

// File: rtl/tx_tagger.sv
module tx_tagger #(
   parameter int REQ_LAT = 2,
   parameter int RSP_LAT = 2,
   parameter int UNB_LAT = 1,
   parameter int LATW    = 3
) (
   input  logic [1:0]      kind,
   output logic [1:0]      vc,
   output logic [LATW-1:0] lat
);
   import msg_sched_pkg::*;

   generate
      if ((REQ_LAT >= (1 << LATW)) || (RSP_LAT >= (1 << LATW)) ||
          (UNB_LAT >= (1 << LATW))) begin : g_bad_lat
         $error("tx_tagger: latency does not fit LATW");
      end
   endgenerate

   always_comb begin
      case (txk_e'(kind))
         TXK_REQ: begin vc = 2'd0; lat = LATW'(REQ_LAT); end
         TXK_RSP: begin vc = 2'd1; lat = LATW'(RSP_LAT); end
         TXK_UNB: begin vc = 2'd2; lat = LATW'(UNB_LAT); end
         default: begin vc = 2'd0; lat = '0;             end
      endcase
   end
endmodule

// File: rtl/msg_rank_sched.sv
module msg_rank_sched
   import msg_sched_pkg::*;
#(
   parameter int AW         = 16,
   parameter int DW         = 16,
   parameter int PARK_DEPTH = 4,
   parameter int REQ_LAT    = 2,
   parameter int RSP_LAT    = 2,
   parameter int UNB_LAT    = 1,
   parameter int LATW       = 3,
   parameter int RSP_IN_VC  = 1,
   parameter int LREQ_IN_VC = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_Q-1:0]           in_valid,
   output logic [NUM_Q-1:0]           in_ready,
   input  logic [NUM_Q-1:0][AW-1:0]   in_addr,
   input  logic [NUM_Q-1:0][DW-1:0]   in_data,
   input  logic                       victim_en,
   input  logic [AW-1:0]              victim_addr,
   output logic [NUM_Q-1:0][AW-1:0]   qry_addr,
   input  logic [NUM_Q-1:0]           qry_blocked,
   input  logic                       wake_valid,
   input  logic [AW-1:0]              wake_addr,
   output logic                       sel_valid,
   output logic [1:0]                 sel_src,
   output logic [1:0]                 sel_vc,
   output logic [AW-1:0]              sel_addr,
   output logic [DW-1:0]              sel_data,
   output logic                       sel_repl,
   input  logic [1:0]                 tx_kind,
   output logic [1:0]                 tx_vc,
   output logic [LATW-1:0]            tx_lat
);
   generate
      if (AW < 1 || DW < 1) begin : g_bad_width
         $error("msg_rank_sched: widths must be positive");
      end
      if (RSP_IN_VC > 3 || LREQ_IN_VC > 3) begin : g_bad_vc
         $error("msg_rank_sched: inbound channel numbers must fit 2 bits");
      end
   endgenerate

   logic [NUM_Q-1:0]         cand_v, gnt;
   logic [NUM_Q-1:0][AW-1:0] cand_a;
   logic [NUM_Q-1:0][DW-1:0] cand_d;
   logic [NUM_Q-1:0]         cand_f;
   logic [1:0]               gnt_idx;
   logic                     any_cand;

   genvar q;
   generate
      for (q = 0; q < NUM_Q; q++) begin : g_lane
         logic [AW-1:0] eff_addr;
         logic          eff_flag;
         if (q == int'(SRC_UREQ)) begin : g_victim
            assign eff_addr = victim_en ? victim_addr : in_addr[q];
            assign eff_flag = victim_en;
         end else begin : g_plain
            assign eff_addr = in_addr[q];
            assign eff_flag = 1'b0;
         end
         assign qry_addr[q] = eff_addr;

         park_lane #(.AW(AW), .DW(DW), .DEPTH(PARK_DEPTH)) i_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .in_valid   (in_valid[q]),
            .in_addr    (eff_addr),
            .in_data    (in_data[q]),
            .in_flag    (eff_flag),
            .blocked    (qry_blocked[q]),
            .grant      (gnt[q]),
            .wake_valid (wake_valid),
            .wake_addr  (wake_addr),
            .in_ready   (in_ready[q]),
            .cand_valid (cand_v[q]),
            .cand_addr  (cand_a[q]),
            .cand_data  (cand_d[q]),
            .cand_flag  (cand_f[q])
         );
      end
   endgenerate

   rank_pick #(.N(NUM_Q)) i_pick (
      .req     (cand_v),
      .gnt     (gnt),
      .gnt_idx (gnt_idx),
      .any     (any_cand)
   );

   assign sel_valid = any_cand;
   assign sel_src   = gnt_idx;
   assign sel_addr  = cand_a[gnt_idx];
   assign sel_data  = cand_d[gnt_idx];
   assign sel_repl  = any_cand & cand_f[gnt_idx];

   always_comb begin
      case (src_e'(gnt_idx))
         SRC_RSP:  sel_vc = 2'(RSP_IN_VC);
         SRC_LREQ: sel_vc = 2'(LREQ_IN_VC);
         default:  sel_vc = 2'd0;
      endcase
   end

   tx_tagger #(.REQ_LAT(REQ_LAT), .RSP_LAT(RSP_LAT), .UNB_LAT(UNB_LAT),
               .LATW(LATW)) i_tag (
      .kind (tx_kind),
      .vc   (tx_vc),
      .lat  (tx_lat)
   );

   // R1
   rank_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_valid && sel_src == 2'(SRC_UREQ)) |-> !(cand_v[0] || cand_v[1]));

   // R1
   one_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|cand_v) |-> (sel_valid && $onehot0(gnt)));

   // R8
   victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid[2] && victim_en) |-> (qry_addr[2] == victim_addr));
endmodule

// File: tb/test_msg_rank_sched.sv
module test_msg_rank_sched;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 16;
   localparam int DW = 16;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic [2:0]           in_valid = '0;
   logic [2:0]           in_ready;
   logic [2:0][AW-1:0]   in_addr = '0;
   logic [2:0][DW-1:0]   in_data = '0;
   logic                 victim_en = 1'b0;
   logic [AW-1:0]        victim_addr = '0;
   logic [2:0][AW-1:0]   qry_addr;
   logic [2:0]           qry_blocked = '0;
   logic                 wake_valid = 1'b0;
   logic [AW-1:0]        wake_addr = '0;
   logic                 sel_valid;
   logic [1:0]           sel_src, sel_vc;
   logic [AW-1:0]        sel_addr;
   logic [DW-1:0]        sel_data;
   logic                 sel_repl;
   logic [1:0]           tx_kind = '0;
   logic [1:0]           tx_vc;
   logic [2:0]           tx_lat;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   msg_rank_sched i_msg_rank_sched (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_addr(in_addr), .in_data(in_data), .victim_en(victim_en),
      .victim_addr(victim_addr), .qry_addr(qry_addr), .qry_blocked(qry_blocked),
      .wake_valid(wake_valid), .wake_addr(wake_addr), .sel_valid(sel_valid),
      .sel_src(sel_src), .sel_vc(sel_vc), .sel_addr(sel_addr), .sel_data(sel_data),
      .sel_repl(sel_repl), .tx_kind(tx_kind), .tx_vc(tx_vc), .tx_lat(tx_lat)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic offer(input int q, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic blk);
      in_valid[q]    = 1'b1;
      in_addr[q]     = a;
      in_data[q]     = d;
      qry_blocked[q] = blk;
   endtask

   task automatic idle();
      in_valid    = '0;
      qry_blocked = '0;
      wake_valid  = 1'b0;
      victim_en   = 1'b0;
   endtask

   task automatic t_reset();
      #1;
      check("R11 idle sel_valid", 32'(sel_valid), 32'd0);
   endtask

   task automatic t_priority();
      offer(0, 16'h10, 16'hA0, 1'b0);
      offer(1, 16'h20, 16'hB0, 1'b0);
      offer(2, 16'h30, 16'hC0, 1'b0);
      #1;
      check("R1 src with all three", 32'(sel_src), 32'd0);
      check("R2 data queue 0", 32'(sel_data), 32'hA0);
      check("R2 ready only winner", 32'(in_ready), 32'b001);
      check("R10 vc queue 0", 32'(sel_vc), 32'd1);
      step();
      in_valid[0] = 1'b0;
      #1;
      check("R1 src with 1 and 2", 32'(sel_src), 32'd1);
      check("R2 data queue 1", 32'(sel_data), 32'hB0);
      check("R10 vc queue 1", 32'(sel_vc), 32'd2);
      step();
      in_valid[1] = 1'b0;
      #1;
      check("R2 src queue 2", 32'(sel_src), 32'd2);
      check("R10 vc queue 2", 32'(sel_vc), 32'd0);
      check("R2 ready queue 2", 32'(in_ready), 32'b100);
      step();
      idle();
   endtask

   task automatic t_park();
      offer(1, 16'h40, 16'h11, 1'b1);
      #1;
      check("R3 blocked not output", 32'(sel_valid), 32'd0);
      check("R3 blocked accepted", 32'(in_ready[1]), 32'd1);
      step();
      offer(1, 16'h40, 16'h12, 1'b0);
      #1;
      check("R4 same address parked", 32'(sel_valid), 32'd0);
      check("R4 accepted", 32'(in_ready[1]), 32'd1);
      step();
      offer(1, 16'h50, 16'h13, 1'b0);
      #1;
      check("R2 other address passes", 32'(sel_data), 32'h13);
      step();
      idle();
      wake_valid = 1'b1;
      wake_addr  = 16'h60;
      step();
      wake_valid = 1'b0;
      #1;
      check("R6 unrelated wake releases none", 32'(sel_valid), 32'd0);
      wake_valid = 1'b1;
      wake_addr  = 16'h40;
      step();
      wake_valid = 1'b0;
      offer(1, 16'h50, 16'h14, 1'b0);
      #1;
      check("R5 first released", 32'(sel_data), 32'h11);
      check("R5 ready low while released", 32'(in_ready[1]), 32'd0);
      step();
      #1;
      check("R5 second released", 32'(sel_data), 32'h12);
      step();
      #1;
      check("R5 new after drain", 32'(sel_data), 32'h14);
      check("R5 ready back", 32'(in_ready[1]), 32'd1);
      step();
      idle();
   endtask

   task automatic t_full();
      for (int k = 0; k < 4; k++) begin
         offer(2, 16'h70, 16'(16'h21 + k), 1'b1);
         #1;
         check("R3 fill accept", 32'(in_ready[2]), 32'd1);
         step();
      end
      offer(2, 16'h80, 16'h25, 1'b0);
      #1;
      check("R7 full ready low", 32'(in_ready[2]), 32'd0);
      check("R7 full no output", 32'(sel_valid), 32'd0);
      idle();
      wake_valid = 1'b1;
      wake_addr  = 16'h70;
      step();
      wake_valid = 1'b0;
      for (int k = 0; k < 4; k++) begin
         #1;
         check("R5 drain order", 32'(sel_data), 32'(16'h21 + k));
         step();
      end
      #1;
      check("R5 drained empty", 32'(sel_valid), 32'd0);
   endtask

   task automatic t_victim();
      offer(2, 16'h90, 16'h31, 1'b0);
      victim_en   = 1'b1;
      victim_addr = 16'hA0;
      #1;
      check("R8 query victim", 32'(qry_addr[2]), 32'hA0);
      check("R8 sel victim addr", 32'(sel_addr), 32'hA0);
      check("R8 replacement flag", 32'(sel_repl), 32'd1);
      step();
      idle();
      offer(2, 16'h90, 16'h32, 1'b0);
      #1;
      check("R8 no victim addr", 32'(sel_addr), 32'h90);
      check("R8 no victim flag", 32'(sel_repl), 32'd0);
      step();
      idle();
   endtask

   task automatic t_same_wake();
      offer(0, 16'hB0, 16'h41, 1'b1);
      wake_valid = 1'b1;
      wake_addr  = 16'hB0;
      #1;
      check("R12 parked not output", 32'(sel_valid), 32'd0);
      step();
      idle();
      #1;
      check("R12 released next cycle", 32'(sel_data), 32'h41);
      check("R12 src", 32'(sel_src), 32'd0);
      step();
   endtask

   task automatic t_tags();
      logic [1:0] evc [4] = '{2'd0, 2'd1, 2'd2, 2'd0};
      logic [2:0] elat [4] = '{3'd2, 3'd2, 3'd1, 3'd0};
      for (int k = 0; k < 4; k++) begin
         tx_kind = 2'(k);
         #1;
         check("R9 tag vc", 32'(tx_vc), 32'(evc[k]));
         check("R9 tag lat", 32'(tx_lat), 32'(elat[k]));
      end
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      @(negedge clk);
      t_priority();
      t_park();
      t_full();
      t_victim();
      t_same_wake();
      t_tags();
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule